// File: doc/BRIEF.md
# Strided Block DMA Engine

This engine copies 32-bit words between an 8 KB local memory and a DRAM word port. The local memory is made of two 4 KB banks, one for data and one for instructions. A single job describes a rectangle of memory: a number of rows, each the same number of bytes long. The local side is packed and contiguous. On the DRAM side a programmable gap is inserted after every row. All job parameters come from one packed 32-bit length word together with a local address, a DRAM address and a direction bit, all sampled on a start pulse.

The engine moves one word on each clock in which the DRAM port is ready. When the last word has moved, it raises `done` for one cycle and captures the final local address, the final DRAM address and a fixed length read-back value. Those values stay on the result ports until the next job completes. The local address never leaves the bank chosen at start: the byte offset wraps modulo 4 KB. DRAM reads beyond the implemented range deliver zero, and DRAM writes beyond that range are dropped.

Top module: `strided_dma`

## Requirements
- R1: The row length in bytes is (len_word[11:0] OR 7) + 1, which is always a multiple of 8 and at most 4096. Each row moves that many bytes divided by 4 words.
- R2: The number of rows is len_word[19:12] + 1, so a job has between 1 and 256 rows.
- R3: After each row, including the last, the DRAM address advances by len_word[31:20] with its three low bits cleared. The local address never advances by this skip.
- R4: The local start offset is loc_addr_in[11:3] times 8. loc_addr_in[12] selects the bank (1 = instruction bank). `lmem_addr` is {bank, offset[11:2]}. The offset wraps modulo 4096 and never changes the bank.
- R5: The DRAM start address is dram_addr_in with its three low bits cleared. Both addresses advance by 4 for every word.
- R6: With dir = 0, words are read from DRAM and written to local memory. With dir = 1, words are read from local memory and written to DRAM. Local and DRAM writes are never issued in the same cycle.
- R7: While busy, a word moves on every cycle in which `dram_ready` is high. While `dram_req` is high and `dram_ready` is low, the address is held and nothing moves. A job of N words with `dram_ready` held high raises `done` N+1 clocks after the clock that samples `start`.
- R8: A DRAM word address at or above DRAM_LIMIT issues no `dram_req` and does not wait for `dram_ready`. For dir = 0, such a word writes zero into local memory. For dir = 1, the word is not written to DRAM.
- R9: `done` is high for exactly one cycle after the last word has moved, and `busy` is low in that cycle.
- R10: When `done` rises, `res_loc_addr` becomes {bank, final wrapped 12-bit offset}, `res_dram_addr` becomes the final DRAM address, and `res_len` becomes 0xFF8. All three hold until the next completion. After reset they are zero.
- R11: A `start` pulse while busy is ignored: the running job and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start strobe; job inputs are sampled with it |
| dir | input | 1 | 0: DRAM to local, 1: local to DRAM |
| loc_addr_in | input | 13 | Local byte address, bit 12 selects the bank |
| dram_addr_in | input | 24 | DRAM byte address |
| len_word | input | 32 | Packed row length, row count and DRAM skip |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_loc_addr | output | 13 | Final local address of the last job |
| res_dram_addr | output | 24 | Final DRAM address of the last job |
| res_len | output | 12 | Length read-back value of the last job |
| lmem_addr | output | 11 | Local memory word address |
| lmem_we | output | 1 | Local memory write enable |
| lmem_wdata | output | 32 | Local memory write data |
| lmem_rdata | input | 32 | Local memory read data, valid in the same cycle |
| dram_req | output | 1 | DRAM access request |
| dram_we | output | 1 | DRAM write (qualifies dram_req) |
| dram_addr | output | 24 | DRAM byte address |
| dram_wdata | output | 32 | DRAM write data |
| dram_rdata | input | 32 | DRAM read data, valid in the same cycle as ready |
| dram_ready | input | 1 | DRAM accepts or delivers the word this cycle |

## Verification
The assertions assume that both memories answer combinationally: `lmem_rdata` and `dram_rdata` must be valid in the cycle their address is presented. They also assume that `dram_ready` may drop at any time while a request is pending, but never needs more than a bounded wait. The bench models both memories as combinational arrays, with DRAM read data derived from the address. It drives `dram_ready` at falling edges, either held high or on a fixed low-every-third-cycle pattern. It issues `start` only as one-cycle pulses that are also aligned to falling edges.

// File: rtl/strided_dma_pkg.sv
package strided_dma_pkg;
    localparam int DATA_W     = 32;
    localparam int DRAM_AW    = 24;
    localparam int LOC_AW     = 13;
    localparam int OFF_W      = LOC_AW - 1;   // byte offset inside a bank
    localparam int LWA_W      = LOC_AW - 2;   // local word address
    localparam int ROWW_W     = OFF_W - 1;    // words per row, up to 1024
    localparam int CNT_W      = 8;            // row count minus one
    localparam int SKIP_W     = DATA_W - OFF_W - CNT_W;
    localparam int ALIGN      = 3;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam logic [OFF_W-1:0] LEN_READBACK = OFF_W'(12'hFF8);

    typedef enum logic {
        DIR_D2L = 1'b0,
        DIR_L2D = 1'b1
    } dir_e;

    typedef struct packed {
        dir_e                dir;
        logic                bank;
        logic [OFF_W-1:0]    off;
        logic [DRAM_AW-1:0]  dram;
        logic [ROWW_W-1:0]   row_words;
        logic [CNT_W-1:0]    rows_m1;
        logic [SKIP_W-1:0]   skip;
    } job_t;

    typedef struct packed {
        logic [OFF_W-1:0]    off;
        logic [DRAM_AW-1:0]  dram;
        logic [ROWW_W-1:0]   words_left;
        logic [CNT_W-1:0]    rows_left;
        logic                last;
    } step_t;

    typedef struct packed {
        logic                busy;
        dir_e                dir;
        logic                bank;
        logic [OFF_W-1:0]    off;
        logic [DRAM_AW-1:0]  dram;
        logic [ROWW_W-1:0]   words_left;
        logic [CNT_W-1:0]    rows_left;
        logic [ROWW_W-1:0]   row_words;
        logic [SKIP_W-1:0]   skip;
        logic                done;
        logic [LOC_AW-1:0]   res_loc;
        logic [DRAM_AW-1:0]  res_dram;
        logic [OFF_W-1:0]    res_len;
    } eng_t;
endpackage

// File: rtl/strided_dma_decode.sv
module strided_dma_decode
    import strided_dma_pkg::*;
(
    input  logic               dir_i,
    input  logic [LOC_AW-1:0]  loc_i,
    input  logic [DRAM_AW-1:0] dram_i,
    input  logic [DATA_W-1:0]  len_i,
    output job_t               job_o
);
    localparam logic [OFF_W-1:0] RND_MASK = OFF_W'((1 << ALIGN) - 1);

    logic [OFF_W:0] row_bytes;
    logic           unused_bits;

    always_comb begin
        row_bytes         = {1'b0, len_i[OFF_W-1:0] | RND_MASK} + (OFF_W + 1)'(1);
        job_o.dir         = dir_e'(dir_i);
        job_o.bank        = loc_i[LOC_AW-1];
        job_o.off         = {loc_i[OFF_W-1:ALIGN], ALIGN'(0)};
        job_o.dram        = {dram_i[DRAM_AW-1:ALIGN], ALIGN'(0)};
        job_o.row_words   = row_bytes[OFF_W:2];
        job_o.rows_m1     = len_i[OFF_W +: CNT_W];
        job_o.skip        = {len_i[DATA_W-1:DATA_W-SKIP_W+ALIGN], ALIGN'(0)};
    end

    assign unused_bits = ^{loc_i[ALIGN-1:0], dram_i[ALIGN-1:0],
                           len_i[DATA_W-SKIP_W+ALIGN-1:DATA_W-SKIP_W]};
endmodule

// File: rtl/strided_dma_range.sv
module strided_dma_range
    import strided_dma_pkg::*;
#(
    parameter int unsigned DRAM_LIMIT = 32'h0080_0000
) (
    input  logic [DRAM_AW-1:0] addr_i,
    output logic               in_range_o
);
    localparam logic [DRAM_AW:0] LIMIT_X = (DRAM_AW + 1)'(DRAM_LIMIT);

    assign in_range_o = ({1'b0, addr_i} < LIMIT_X);
endmodule

// File: rtl/strided_dma_step.sv
module strided_dma_step
    import strided_dma_pkg::*;
(
    input  logic [OFF_W-1:0]   off_i,
    input  logic [DRAM_AW-1:0] dram_i,
    input  logic [ROWW_W-1:0]  words_left_i,
    input  logic [CNT_W-1:0]   rows_left_i,
    input  logic [ROWW_W-1:0]  row_words_i,
    input  logic [SKIP_W-1:0]  skip_i,
    output step_t              nxt_o
);
    logic               row_end;
    logic [DRAM_AW-1:0] dram_inc;

    always_comb begin
        row_end    = (words_left_i == ROWW_W'(1));
        dram_inc   = dram_i + DRAM_AW'(WORD_BYTES);
        nxt_o.off  = off_i + OFF_W'(WORD_BYTES);
        nxt_o.last = row_end && (rows_left_i == '0);
        if (row_end) begin
            nxt_o.dram       = dram_inc + DRAM_AW'(skip_i);
            nxt_o.words_left = row_words_i;
            nxt_o.rows_left  = rows_left_i - CNT_W'(1);
        end else begin
            nxt_o.dram       = dram_inc;
            nxt_o.words_left = words_left_i - ROWW_W'(1);
            nxt_o.rows_left  = rows_left_i;
        end
    end
endmodule

// File: rtl/strided_dma.sv
module strided_dma
    import strided_dma_pkg::*;
#(
    parameter int unsigned DRAM_LIMIT = 32'h0080_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               dir,
    input  logic [12:0]        loc_addr_in,
    input  logic [23:0]        dram_addr_in,
    input  logic [31:0]        len_word,
    output logic               busy,
    output logic               done,
    output logic [12:0]        res_loc_addr,
    output logic [23:0]        res_dram_addr,
    output logic [11:0]        res_len,
    output logic [10:0]        lmem_addr,
    output logic               lmem_we,
    output logic [31:0]        lmem_wdata,
    input  logic [31:0]        lmem_rdata,
    output logic               dram_req,
    output logic               dram_we,
    output logic [23:0]        dram_addr,
    output logic [31:0]        dram_wdata,
    input  logic [31:0]        dram_rdata,
    input  logic               dram_ready
);
    eng_t  st_d, st_q;
    job_t  job;
    step_t nxt;
    logic  in_range;
    logic  adv;

    strided_dma_decode u_decode (
        .dir_i  (dir),
        .loc_i  (loc_addr_in),
        .dram_i (dram_addr_in),
        .len_i  (len_word),
        .job_o  (job)
    );

    strided_dma_range #(.DRAM_LIMIT(DRAM_LIMIT)) u_range (
        .addr_i     (st_q.dram),
        .in_range_o (in_range)
    );

    strided_dma_step u_step (
        .off_i        (st_q.off),
        .dram_i       (st_q.dram),
        .words_left_i (st_q.words_left),
        .rows_left_i  (st_q.rows_left),
        .row_words_i  (st_q.row_words),
        .skip_i       (st_q.skip),
        .nxt_o        (nxt)
    );

    always_comb begin
        adv  = st_q.busy && (!in_range || dram_ready);
        st_d = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy       = 1'b1;
                st_d.dir        = job.dir;
                st_d.bank       = job.bank;
                st_d.off        = job.off;
                st_d.dram       = job.dram;
                st_d.row_words  = job.row_words;
                st_d.words_left = job.row_words;
                st_d.rows_left  = job.rows_m1;
                st_d.skip       = job.skip;
            end
        end else if (adv) begin
            st_d.off        = nxt.off;
            st_d.dram       = nxt.dram;
            st_d.words_left = nxt.words_left;
            st_d.rows_left  = nxt.rows_left;
            if (nxt.last) begin
                st_d.busy     = 1'b0;
                st_d.done     = 1'b1;
                st_d.res_loc  = {st_q.bank, nxt.off};
                st_d.res_dram = nxt.dram;
                st_d.res_len  = LEN_READBACK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy          = st_q.busy;
    assign done          = st_q.done;
    assign res_loc_addr  = st_q.res_loc;
    assign res_dram_addr = st_q.res_dram;
    assign res_len       = st_q.res_len;

    assign lmem_addr  = {st_q.bank, st_q.off[OFF_W-1:2]};
    assign lmem_we    = adv && (st_q.dir == DIR_D2L);
    assign lmem_wdata = in_range ? dram_rdata : '0;

    assign dram_req   = st_q.busy && in_range;
    assign dram_we    = dram_req && (st_q.dir == DIR_L2D);
    assign dram_addr  = st_q.dram;
    assign dram_wdata = lmem_rdata;
endmodule

// File: rtl/strided_dma_chk.sv
module strided_dma_chk #(
    parameter int unsigned DRAM_LIMIT = 32'h0080_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [11:0] res_len,
    input logic [10:0] lmem_addr,
    input logic        lmem_we,
    input logic        dram_req,
    input logic        dram_we,
    input logic [23:0] dram_addr,
    input logic        dram_ready
);
    localparam logic [24:0] LIMIT_X = 25'(DRAM_LIMIT);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_len == 12'hFF8);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_req && !dram_ready) |=> (busy && $stable(dram_addr)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!dram_req && !lmem_we));

    assert_one_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lmem_we && dram_we));

    assert_req_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dram_req |-> ({1'b0, dram_addr} < LIMIT_X));

    assert_bank_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> lmem_addr[10] == $past(lmem_addr[10]));
endmodule

bind strided_dma strided_dma_chk #(.DRAM_LIMIT(DRAM_LIMIT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .res_len    (res_len),
    .lmem_addr  (lmem_addr),
    .lmem_we    (lmem_we),
    .dram_req   (dram_req),
    .dram_we    (dram_we),
    .dram_addr  (dram_addr),
    .dram_ready (dram_ready)
);

// File: tb/strided_dma_tb_top.sv
module strided_dma_tb_top;
    localparam int LIMIT = 32'h0080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir = 1'b0;
    logic [12:0] loc_addr_in = '0;
    logic [23:0] dram_addr_in = '0;
    logic [31:0] len_word = '0;
    logic        busy, done;
    logic [12:0] res_loc_addr;
    logic [23:0] res_dram_addr;
    logic [11:0] res_len;
    logic [10:0] lmem_addr;
    logic        lmem_we;
    logic [31:0] lmem_wdata, lmem_rdata;
    logic        dram_req, dram_we;
    logic [23:0] dram_addr;
    logic [31:0] dram_wdata, dram_rdata;
    logic        dram_ready = 1'b1;

    logic [31:0] lmem_m [0:2047];
    logic [31:0] dram_w [int];
    int          checks = 0;
    int          failures = 0;
    int          cyc_cnt = 0;
    logic        stall_en = 1'b0;

    always #5 clk = ~clk;

    strided_dma #(.DRAM_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir),
        .loc_addr_in(loc_addr_in), .dram_addr_in(dram_addr_in), .len_word(len_word),
        .busy(busy), .done(done), .res_loc_addr(res_loc_addr),
        .res_dram_addr(res_dram_addr), .res_len(res_len),
        .lmem_addr(lmem_addr), .lmem_we(lmem_we), .lmem_wdata(lmem_wdata),
        .lmem_rdata(lmem_rdata), .dram_req(dram_req), .dram_we(dram_we),
        .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
        .dram_ready(dram_ready)
    );

    function automatic logic [31:0] pat(input logic [23:0] a);
        return {8'hA5, a} ^ 32'h0013_5700;
    endfunction

    assign dram_rdata = pat(dram_addr);
    assign lmem_rdata = lmem_m[lmem_addr];

    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (lmem_we) lmem_m[lmem_addr] <= lmem_wdata;
        if (dram_req && dram_we && dram_ready) dram_w[int'(dram_addr)] = dram_wdata;
    end

    always @(negedge clk) dram_ready <= stall_en ? ((cyc_cnt % 3) != 2) : 1'b1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic fill_lmem();
        for (int i = 0; i < 2048; i++) lmem_m[i] = 32'h5A00_0000 + i;
        dram_w.delete();
    endtask

    task automatic pulse_start(input logic d, input logic [12:0] la,
                               input logic [23:0] da, input logic [31:0] lw);
        @(negedge clk);
        start = 1'b1; dir = d; loc_addr_in = la; dram_addr_in = da; len_word = lw;
        @(negedge clk);
        start = 1'b0;
    endtask

    // cycles counted from the clock that samples start (that clock counts as 1)
    task automatic run_job(input logic d, input logic [12:0] la, input logic [23:0] da,
                           input logic [31:0] lw, output int cyc);
        pulse_start(d, la, da, lw);
        cyc = 1;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // data and result checks derived from the requirements
    task automatic verify(input logic d, input logic [12:0] la, input logic [23:0] da,
                          input logic [31:0] lw, input string tag);
        int rowb = int'(lw[11:0] | 12'h7) + 1;
        int nrow = int'(lw[19:12]) + 1;
        int skip = int'(lw[31:20]) & 32'hFF8;
        int off0 = int'(la) & 32'hFF8;
        int bank = int'(la[12]);
        int d0   = int'(da) & 32'hFFFFF8;
        int bad = 0;
        int nwr = 0;
        longint a_act = 0, a_exp = 0;
        for (int r = 0; r < nrow; r++) begin
            for (int w = 0; w < rowb / 4; w++) begin
                int dr = (d0 + r * (rowb + skip) + 4 * w) & 32'hFFFFFF;
                int lo = (off0 + 4 * (r * (rowb / 4) + w)) & 32'hFFF;
                int idx = bank * 1024 + lo / 4;
                if (d == 1'b0) begin
                    logic [31:0] e = (dr < LIMIT) ? pat(24'(dr)) : 32'h0;
                    if (lmem_m[idx] !== e && bad == 0) begin a_act = lmem_m[idx]; a_exp = e; end
                    if (lmem_m[idx] !== e) bad++;
                end else if (dr < LIMIT) begin
                    nwr++;
                    if (!dram_w.exists(dr) || dram_w[dr] !== lmem_m[idx]) begin
                        if (bad == 0) begin a_act = dr; a_exp = lmem_m[idx]; end
                        bad++;
                    end
                end
            end
        end
        check(bad == 0, {tag, " data"}, a_act, a_exp);
        if (d == 1'b1) check(dram_w.num() == nwr, {tag, " R8 dram write count"}, dram_w.num(), nwr);
        else check(dram_w.num() == 0, {tag, " R6 no dram writes"}, dram_w.num(), 0);
        check(res_dram_addr == 24'((d0 + nrow * (rowb + skip)) & 32'hFFFFFF),
              {tag, " R3 R10 final dram"}, res_dram_addr, (d0 + nrow * (rowb + skip)) & 32'hFFFFFF);
        check(res_loc_addr == 13'(bank * 4096 + ((off0 + nrow * rowb) & 32'hFFF)),
              {tag, " R4 R10 final local"}, res_loc_addr, bank * 4096 + ((off0 + nrow * rowb) & 32'hFFF));
        check(res_len == 12'hFF8, {tag, " R10 len readback"}, res_len, 12'hFF8);
    endtask

    task automatic t_reset();
        check(!busy && !done, "R9 reset idle", {busy, done}, 0);
        check(res_len == 0 && res_loc_addr == 0 && res_dram_addr == 0, "R10 reset results",
              res_len, 0);
        check(!dram_req && !lmem_we, "R7 reset quiet", {dram_req, lmem_we}, 0);
    endtask

    task automatic t_simple_d2l();
        int c;
        fill_lmem();
        run_job(1'b0, 13'h0010, 24'h000100, 32'h0000_000F, c);
        check(c == 5, "R1 R7 cycles for 4 words", c, 5);
        verify(1'b0, 13'h0010, 24'h000100, 32'h0000_000F, "R1 R5 R6 d2l");
        check(lmem_m[3] == 32'h5A00_0003 && lmem_m[8] == 32'h5A00_0008,
              "R1 neighbours untouched", lmem_m[8], 32'h5A00_0008);
        @(negedge clk);
        check(!done, "R9 done one cycle", done, 0);
    endtask

    task automatic t_strided_l2d_wrap();
        int c;
        fill_lmem();
        run_job(1'b1, 13'h1FFB, 24'h002003, 32'h10C0_2007, c);
        check(c == 7, "R2 cycles for 3 rows of 2 words", c, 7);
        verify(1'b1, 13'h1FFB, 24'h002003, 32'h10C0_2007, "R2 R3 R4 R6 l2d wrap");
        check(res_loc_addr == 13'h1010, "R4 bank wrap result", res_loc_addr, 13'h1010);
        check(res_dram_addr == 24'h002330, "R3 skip result", res_dram_addr, 24'h002330);
    endtask

    task automatic t_stall();
        int c;
        fill_lmem();
        stall_en = 1'b1;
        run_job(1'b0, 13'h0200, 24'h004000, 32'h0200_1017, c);
        stall_en = 1'b0;
        check(c > 13, "R7 stalls lengthen job", c, 13);
        verify(1'b0, 13'h0200, 24'h004000, 32'h0200_1017, "R7 stalled d2l");
    endtask

    task automatic t_out_of_range();
        int c;
        fill_lmem();
        run_job(1'b0, 13'h0040, 24'h7FFFF8, 32'h0000_000F, c);
        verify(1'b0, 13'h0040, 24'h7FFFF8, 32'h0000_000F, "R8 d2l zero fill");
        check(lmem_m[18] == 32'h0, "R8 zero word", lmem_m[18], 0);
        fill_lmem();
        run_job(1'b1, 13'h0040, 24'h7FFFF8, 32'h0000_000F, c);
        verify(1'b1, 13'h0040, 24'h7FFFF8, 32'h0000_000F, "R8 l2d dropped");
        check(!dram_w.exists(32'h800000), "R8 no write past limit", dram_w.num(), 2);
    endtask

    task automatic t_full_bank();
        int c;
        fill_lmem();
        run_job(1'b0, 13'h0800, 24'h001000, 32'h0000_0FFF, c);
        check(c == 1025, "R1 max row length cycles", c, 1025);
        verify(1'b0, 13'h0800, 24'h001000, 32'h0000_0FFF, "R1 R4 full bank");
        check(res_loc_addr == 13'h0800, "R4 full wrap", res_loc_addr, 13'h0800);
    endtask

    task automatic t_start_busy();
        int c;
        fill_lmem();
        pulse_start(1'b0, 13'h0100, 24'h003000, 32'h0000_001F);
        @(negedge clk);
        start = 1'b1; dir = 1'b1; loc_addr_in = 13'h1300; dram_addr_in = 24'h005000;
        len_word = 32'h0000_0007;
        @(negedge clk);
        start = 1'b0;
        c = 3;
        while (!done && c < 5000) begin @(negedge clk); c++; end
        check(c == 9, "R11 job length unchanged", c, 9);
        verify(1'b0, 13'h0100, 24'h003000, 32'h0000_001F, "R11 ignored start");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R9 actual=busy expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_simple_d2l();
        t_strided_l2d_wrap();
        t_stall();
        t_out_of_range();
        t_full_bank();
        t_start_busy();
        check(res_len == 12'hFF8, "R10 results held", res_len, 12'hFF8);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule